// File: doc/BRIEF.md
# Ping-Pong Video Row Serializer

This block is the serial read-out stage of a video memory. A complete memory row arrives on a wide parallel port in one transfer cycle. The block stores it in one of two row-wide buffers. The other buffer streams one bit per cycle on the serial output whenever the video-rate shift enable is high. Loading and shifting never wait for each other. A new row can therefore be written during a single host transfer slot while the previous row keeps streaming, and the stream crosses from one row to the next with no idle bit.

Loads fill the two buffers in strict alternation, starting with buffer 0. Shifting drains them in the same order, starting at column 0 of each row. A request flag tells the memory-side sequencer when a buffer is free to take the next row. Two status flags report the two ways the stream can go wrong: a shift with no data ready (underrun), and a load while the target buffer still holds unsent bits (overrun). The row width is a parameter, with a default of 512 bits.

Top module: `vs_serializer`

## Requirements
- R1: After a synchronous active-low reset, both buffers are empty, `ser_out` is 0, `row_req` is 1, and `underrun` and `overrun` are 0.
- R2: Accepted loads alternate between the two buffers, buffer 0 first. A load takes one cycle, and from the next cycle the loaded buffer counts as full.
- R3: `ser_out` shows bit k of the active full row. k starts at 0 (column 0 is the least significant bit of `load_row`) and advances by one on each cycle with `shift_en` high. It holds while `shift_en` is low.
- R4: The shift cycle that emits bit ROW_W-1 empties the active buffer and makes the other buffer active. If that buffer is full, its column 0 appears on `ser_out` in the very next cycle, with no gap.
- R5: `row_req` is 1 whenever at least one buffer is empty. It is 0 only while both buffers are full.
- R6: A cycle with `shift_en` high while the active buffer is empty sets `underrun`. While the active buffer is empty, `ser_out` is 0. `underrun` clears on the cycle that a load fills the active buffer, and the load takes priority over the shift in that cycle.
- R7: A `load_stb` while the target buffer is still full is ignored and leaves the streamed data unchanged. It sets `overrun`, which stays at 1 until reset.
- R8: A load and a shift in the same cycle both take effect, on different buffers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_stb | input | 1 | Row transfer strobe |
| load_row | input | ROW_W | Row data; bit 0 is column 0 |
| shift_en | input | 1 | Video-rate shift enable |
| ser_out | output | 1 | Serial video bit |
| row_req | output | 1 | At least one buffer can take a row |
| underrun | output | 1 | Shift attempted with no data ready |
| overrun | output | 1 | Sticky: a load hit a full buffer |

## Verification
The bench builds the block with ROW_W = 8. At that width a full row drains in eight shifts, so thousands of load and shift patterns can run many complete ping-pong cycles. These runs reach every bit position, the wrap from bit 7 into the other buffer, overruns from back-to-back loads, and underruns with a load landing in the same cycle. A behavioural queue model in the bench predicts every output on every cycle. The sweep runs over all 16 four-cycle shift-enable patterns combined with several load spacings.

// File: rtl/vs_pkg.sv
// Package: shared constants and types for the video row serializer.
// Assumes exactly two row buffers used in ping-pong fashion.
package vs_pkg;
    localparam int N_BUF = 2;
    typedef logic [N_BUF-1:0] buf_mask_t;
endpackage

// File: rtl/vs_row_buf.sv
// Module: one row-wide buffer. It loads a row in parallel and shifts it
// towards bit 0 one bit per enabled cycle.
// Assumes the controller never loads and shifts the same buffer in one cycle.
module vs_row_buf #(
    parameter int ROW_W = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [ROW_W-1:0] load_data,
    input  logic             shift_en,
    output logic             head
);
    logic [ROW_W-1:0] data_q;

    // Holds the row: parallel load, or a right shift that exposes the next column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_en) begin
            data_q <= load_data;
        end else if (shift_en) begin
            data_q <= {1'b0, data_q[ROW_W-1:1]};
        end
    end

    assign head = data_q[0];

    // R8: the buffer being loaded is never the buffer being shifted
    a_r8_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && shift_en));
endmodule

// File: rtl/vs_seq_ctrl.sv
// Module: ping-pong sequencer. It tracks which buffers are full, the fill
// and drain pointers, and the bit position in the active row, and it
// raises the request, underrun and overrun flags.
// Assumes one load strobe and one shift enable per cycle.
module vs_seq_ctrl
    import vs_pkg::*;
#(
    parameter int ROW_W = 512
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_stb,
    input  logic      shift_en,
    output buf_mask_t load_sel,
    output buf_mask_t shift_sel,
    output logic      act,
    output buf_mask_t full,
    output logic      row_req,
    output logic      underrun,
    output logic      overrun
);
    localparam int PW = (ROW_W > 1) ? $clog2(ROW_W) : 1;
    localparam logic [PW-1:0] LAST = PW'(ROW_W - 1);

    logic          wr_sel;
    logic [PW-1:0] pos;
    logic          load_ok, shift_ok, at_last;
    buf_mask_t     drained;

    assign load_ok  = load_stb && !full[wr_sel];
    assign shift_ok = shift_en && full[act];
    assign at_last  = (pos == LAST);

    // Decodes the accepted load and shift into one strobe per buffer.
    always_comb begin
        load_sel  = '0;
        shift_sel = '0;
        if (load_ok)  load_sel[wr_sel] = 1'b1;
        if (shift_ok) shift_sel[act]   = 1'b1;
    end

    assign drained = at_last ? shift_sel : '0;

    // Full flags: set by an accepted load, cleared when the last bit leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) full <= '0;
        else        full <= (full & ~drained) | load_sel;
    end

    // Fill pointer: moves to the other buffer after each accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_sel <= 1'b0;
        else if (load_ok) wr_sel <= ~wr_sel;
    end

    // Drain pointer and bit position: the position wraps to the other buffer after the last column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
            pos <= '0;
        end else if (shift_ok) begin
            if (at_last) begin
                act <= ~act;
                pos <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    // Underrun: set by a shift with no data, cleared when the active buffer is filled.
    always_ff @(posedge clk) begin
        if (!rst_n)                          underrun <= 1'b0;
        else if (load_ok && (wr_sel == act)) underrun <= 1'b0;
        else if (shift_en && !full[act])     underrun <= 1'b1;
    end

    // Overrun: sticky record of a load that hit a full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                           overrun <= 1'b0;
        else if (load_stb && full[wr_sel])    overrun <= 1'b1;
    end

    assign row_req = ~&full;

    // R3: the bit position never runs past the last column
    a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST);
    // R5: draining a row always frees a buffer for the sequencer
    a_r5_req_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_ok && at_last) |=> row_req);
    // R7: overrun is sticky until reset
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

// File: rtl/vs_serializer.sv
// Module: top of the ping-pong video row serializer. It instantiates two
// row buffers and the sequencer, and selects the serial bit from the active buffer.
// Assumes load_row is valid in the cycle load_stb is high.
module vs_serializer
    import vs_pkg::*;
#(
    parameter int ROW_W = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [ROW_W-1:0] load_row,
    input  logic             shift_en,
    output logic             ser_out,
    output logic             row_req,
    output logic             underrun,
    output logic             overrun
);
    buf_mask_t load_sel, shift_sel, full, heads;
    logic      act;

    vs_seq_ctrl #(.ROW_W(ROW_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .shift_en(shift_en),
        .load_sel(load_sel), .shift_sel(shift_sel), .act(act), .full(full),
        .row_req(row_req), .underrun(underrun), .overrun(overrun)
    );

    for (genvar i = 0; i < N_BUF; i++) begin : g_buf
        vs_row_buf #(.ROW_W(ROW_W)) u_buf (
            .clk(clk), .rst_n(rst_n), .load_en(load_sel[i]),
            .load_data(load_row), .shift_en(shift_sel[i]), .head(heads[i])
        );
    end

    // Output select: the active head bit, forced to 0 when that buffer is empty.
    always_comb ser_out = full[act] ? heads[act] : 1'b0;

    // R6: an underrunning stream stays silent
    a_r6_silent_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !ser_out);
endmodule

// File: tb/sim_vs_serializer.sv
module sim_vs_serializer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_stb = 1'b0;
    logic [W-1:0] load_row = '0;
    logic         shift_en = 1'b0;
    logic         ser_out, row_req, underrun, overrun;

    int vectors = 0;
    int fails = 0;

    // reference state, derived from the requirements
    logic [W-1:0] mrow [2];
    logic [1:0]   mf;
    logic         mact, mwr, mund, mov;
    int           mpos;

    always #2 clk = ~clk;   // 250 MHz

    vs_serializer #(.ROW_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_row(load_row),
        .shift_en(shift_en), .ser_out(ser_out), .row_req(row_req),
        .underrun(underrun), .overrun(overrun)
    );

    task automatic model_reset();
        mrow[0] = '0; mrow[1] = '0; mf = 2'b00;
        mact = 1'b0; mwr = 1'b0; mund = 1'b0; mov = 1'b0; mpos = 0;
    endtask

    // compare every output against the model: R3/R4 serial bit, R5 request, R6 underrun, R7 overrun
    task automatic check(input string tag);
        logic e_ser, e_req;
        e_ser = mf[mact] ? mrow[mact][mpos] : 1'b0;
        e_req = !(mf[0] && mf[1]);
        vectors++;
        if (ser_out !== e_ser) begin
            fails++; $display("FAIL %s R3/R4 ser_out got %b exp %b", tag, ser_out, e_ser);
        end
        if (row_req !== e_req) begin
            fails++; $display("FAIL %s R5 row_req got %b exp %b", tag, row_req, e_req);
        end
        if (underrun !== mund) begin
            fails++; $display("FAIL %s R6 underrun got %b exp %b", tag, underrun, mund);
        end
        if (overrun !== mov) begin
            fails++; $display("FAIL %s R7 overrun got %b exp %b", tag, overrun, mov);
        end
    endtask

    // one cycle: check at the falling edge, drive inputs, then advance the model after the rising edge
    task automatic step(input logic ld, input logic [W-1:0] row, input logic sh, input string tag);
        logic o_full_wr, o_full_act, o_act, o_wr;
        @(negedge clk);
        check(tag);
        load_stb = ld; load_row = row; shift_en = sh;
        @(posedge clk);
        #1;
        o_full_wr = mf[mwr]; o_full_act = mf[mact]; o_act = mact; o_wr = mwr;
        // R8: a shift and a load in one cycle both take effect
        if (sh) begin
            if (o_full_act) begin
                if (mpos == W-1) begin mf[o_act] = 1'b0; mact = ~o_act; mpos = 0; end
                else mpos++;
            end else mund = 1'b1;
        end
        if (ld) begin
            if (o_full_wr) mov = 1'b1;          // R7: the load is ignored
            else begin                          // R2: alternate fill
                mrow[o_wr] = row; mf[o_wr] = 1'b1; mwr = ~o_wr;
                if (o_wr == o_act) mund = 1'b0; // R6: the load wins
            end
        end
        load_stb = 1'b0; shift_en = 1'b0;
    endtask

    function automatic logic [W-1:0] pat(input int k);
        return W'((k * 37 + 91) ^ (k >> 2));
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        model_reset();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        model_reset();
        do_reset();
        step(0, '0, 0, "R1 reset");
        step(0, '0, 1, "R1 idle shift");              // shift on empty -> R6 underrun
        step(1, 8'hA5, 0, "R6 load clears underrun");
        step(1, 8'h3C, 0, "R2 second load");
        step(0, '0, 0, "R5 both full");
        step(1, 8'hFF, 0, "R7 overrun load");
        for (int i = 0; i < 8; i++) step(0, '0, 1, "R3 stream A");
        for (int i = 0; i < 3; i++) step(0, '0, 0, "R3 hold");
        for (int i = 0; i < 8; i++) step(0, '0, 1, "R4 stream B");
        step(1, 8'h81, 1, "R6 load+shift underrun");
        for (int i = 0; i < 9; i++) step(0, '0, 1, "R4 drain");
        // sweep: every 4-cycle shift-enable pattern crossed with load spacings
        for (int sp = 1; sp <= 12; sp++) begin
            do_reset();
            for (int p = 0; p < 16; p++) begin
                for (int c = 0; c < 16; c++) begin
                    logic ld_now;
                    ld_now = ((c % sp) == 0);
                    step(ld_now, pat(p * 16 + c + sp), p[c % 4], "R8 sweep");
                end
            end
            for (int c = 0; c < 20; c++) step(0, '0, 1, "R4 sweep drain");
        end
        step(0, '0, 0, "final");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule